// File: doc/BRIEF.md
# Flash Write-Status and Erase-Suspend Unit

This block produces the word a host sees when it reads a NOR flash while an internal program or erase is running. A command decoder feeds it single-cycle start, suspend and resume events. Internal cycle counters stand in for the busy timer, and their durations are parameters. On every read the unit merges three status bits into the word that the array supplies: a polling bit, a toggle bit and a second toggle bit. Which bits it sets depends on the operation in progress, on whether an erase is suspended, and on whether the read address falls inside the suspended sector or block.

An erase covers a sector, a block or the whole array. A sector or block erase can be suspended. The unit then holds the erase counter, waits a programmable entry delay, and enters a readable suspended state. In that state the other regions return plain array data and may be programmed. A resume continues the same erase from where its counter stopped. A synchronous reset abandons any operation and returns the unit to plain reads. The array itself is outside the block and arrives on `arr_rdata`.

Top module: `flash_wstat_unit`

## Requirements
- R1: After reset, `busy` and `in_susp` are 0 and a read returns `arr_rdata` unchanged.
- R2: A program started from idle keeps `busy` high for exactly PROG_CYC clock cycles. During that time bit 7 of a read is the inverse of `wr_poll_bit` and bit 6 is the toggle bit. Afterwards reads return array data.
- R3: While an erase runs, bit 7 of a read is 0. `busy` stays high for ERASE_CYC cycles for a sector (`erase_kind`=0) or block (`erase_kind`=1) erase, and for CHIP_CYC cycles for a whole-array erase (`erase_kind`[1]=1).
- R4: The toggle bit starts at 0 after reset and inverts once each time `rd_sel` falls after being high. Clock cycles without a completed read leave it unchanged.
- R5: During an erase, bit 2 follows the toggle bit, as bit 6 does. During a program, bit 2 is the array bit. Bits other than 7, 6 and 2 always equal `arr_rdata`.
- R6: A `suspend_req` during a sector or block erase holds the erase, keeps `busy` high and the erase status on reads for SUSP_CYC cycles, then drops `busy` and raises `in_susp`.
- R7: While the unit is suspended, a read inside the suspended region returns bit 7 = 1, bit 6 = 1 and bit 2 = the toggle bit.
- R8: While the unit is suspended, a read outside the suspended region returns array data. A sector is the set of addresses that match the erase address in all bits from SECT_W up. A block is the set that match in all bits from BLK_W up.
- R9: While the unit is suspended, `start_prog` at an address outside the region runs a program with the R2 status and timing and then returns to the suspended state. A program inside the region is ignored.
- R10: A `resume_req` while the unit is suspended clears `in_susp` and continues the erase. The erase then ends once the cycles spent erasing, before and after the suspend, add up to the R3 duration.
- R11: `start_prog` and `start_erase` are ignored while `busy` is high. `suspend_req` is ignored during a program or a whole-array erase. `resume_req` is ignored unless the unit is suspended.
- R12: A synchronous `rst` during any operation or suspend returns the unit to the R1 state on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_prog | input | 1 | Pulse that starts a word program at `op_addr` |
| start_erase | input | 1 | Pulse that starts an erase around `op_addr` |
| erase_kind | input | 2 | Erase extent: 0 sector, 1 block, 2 or 3 whole array |
| op_addr | input | AW | Word address of the program or erase |
| wr_poll_bit | input | 1 | Bit 7 of the word being programmed |
| suspend_req | input | 1 | Pulse requesting an erase suspend |
| resume_req | input | 1 | Pulse resuming a suspended erase |
| rd_sel | input | 1 | High while a read is active (chip and output enables both asserted) |
| rd_addr | input | AW | Read address |
| arr_rdata | input | DW | Array word at `rd_addr` |
| rd_data | output | DW | Word returned to the host |
| busy | output | 1 | An internal program, erase or suspend entry is in progress |
| in_susp | output | 1 | An erase is suspended |

## Verification
The bench walks the edges of a suspended sector: its first and last words, the words just outside it, and far addresses. A region decoder that compared the wrong address bits would return array data inside the region or status bits outside it. It times the suspend entry, and it times the resumed erase after a suspend that lands partway through. A counter that reloaded on resume, or kept running while suspended, would give the wrong remaining length. It checks that idle clocks between reads leave the toggle bit unchanged, which exposes a toggle driven by the clock. It also issues the commands that must be ignored: a suspend during a whole-array erase, a program inside the suspended region, and starts while busy. A design that accepted any of these would show stray `in_susp`, `busy` or erase activity.

// File: rtl/fws_pkg.sv
package fws_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PROG  = 3'd1,
      ST_ERASE = 3'd2,
      ST_SWAIT = 3'd3,
      ST_SUSP  = 3'd4,
      ST_SPROG = 3'd5
   } fws_state_e;

   // status bit positions seen by host polling software
   localparam int POLL_BIT = 7;
   localparam int TOG_BIT  = 6;
   localparam int RGN_BIT  = 2;
endpackage

// File: rtl/fws_timer.sv
module fws_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                          cnt_q <= '0;
      else if (load)                    cnt_q <= load_val;
      else if (run && cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
   end

   assign done = run && (cnt_q == CW'(1));
endmodule

// File: rtl/fws_region.sv
module fws_region #(
   parameter int AW     = 12,
   parameter int SECT_W = 5,
   parameter int BLK_W  = 8
) (
   input  logic [AW-1:0] base,
   input  logic [1:0]    kind,
   input  logic [AW-1:0] addr,
   output logic          hit
);
   localparam logic [AW-1:0] ONES   = {AW{1'b1}};
   localparam logic [AW-1:0] S_MASK = ONES << SECT_W;
   localparam logic [AW-1:0] B_MASK = ONES << BLK_W;

   logic [AW-1:0] diff;
   assign diff = addr ^ base;

   always_comb begin
      if (kind[1])      hit = 1'b1;
      else if (kind[0]) hit = (diff & B_MASK) == '0;
      else              hit = (diff & S_MASK) == '0;
   end
endmodule

// File: rtl/fws_toggle.sv
module fws_toggle #(
   parameter bit FLIP_ON_END = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic rd_sel,
   output logic tog
);
   logic sel_q;
   logic flip;

   generate
      if (FLIP_ON_END) begin : g_end
         assign flip = sel_q && !rd_sel;
      end else begin : g_start
         assign flip = !sel_q && rd_sel;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= 1'b0;
         tog   <= 1'b0;
      end else begin
         sel_q <= rd_sel;
         if (flip) tog <= ~tog;
      end
   end
endmodule

// File: rtl/flash_wstat_unit.sv
module flash_wstat_unit
   import fws_pkg::*;
#(
   parameter int AW          = 12,
   parameter int DW          = 16,
   parameter int SECT_W      = 5,
   parameter int BLK_W       = 8,
   parameter int PROG_CYC    = 8,
   parameter int ERASE_CYC   = 20,
   parameter int CHIP_CYC    = 40,
   parameter int SUSP_CYC    = 6,
   parameter bit FLIP_ON_END = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_prog,
   input  logic          start_erase,
   input  logic [1:0]    erase_kind,
   input  logic [AW-1:0] op_addr,
   input  logic          wr_poll_bit,
   input  logic          suspend_req,
   input  logic          resume_req,
   input  logic          rd_sel,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] arr_rdata,
   output logic [DW-1:0] rd_data,
   output logic          busy,
   output logic          in_susp
);
   localparam int M1   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int M2   = (CHIP_CYC > SUSP_CYC) ? CHIP_CYC : SUSP_CYC;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (!(SECT_W > 0 && SECT_W < BLK_W && BLK_W < AW)) begin : g_bad_geom
         $error("region widths must satisfy 0 < SECT_W < BLK_W < AW");
      end
      if (DW < 8) begin : g_bad_dw
         $error("DW must hold the status bits");
      end
      if (PROG_CYC < 2 || ERASE_CYC < 2 || CHIP_CYC < 2 || SUSP_CYC < 2) begin : g_bad_cyc
         $error("all durations must be at least two cycles");
      end
   endgenerate

   fws_state_e    st_q, st_d;
   logic [AW-1:0] er_base_q;
   logic [1:0]    er_kind_q;
   logic          poll_q;
   logic          prog_done, er_done, sus_done;
   logic          prog_load, er_load, sus_load;
   logic          hit_rd, hit_op, tog;

   fws_region #(.AW(AW), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_rgn_rd (
      .base(er_base_q), .kind(er_kind_q), .addr(rd_addr), .hit(hit_rd));

   fws_region #(.AW(AW), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_rgn_op (
      .base(er_base_q), .kind(er_kind_q), .addr(op_addr), .hit(hit_op));

   fws_toggle #(.FLIP_ON_END(FLIP_ON_END)) u_tog (
      .clk(clk), .rst(rst), .rd_sel(rd_sel), .tog(tog));

   fws_timer #(.CW(CW)) u_prog_tmr (
      .clk(clk), .rst(rst), .load(prog_load), .load_val(CW'(PROG_CYC)),
      .run(st_q == ST_PROG || st_q == ST_SPROG), .done(prog_done));

   fws_timer #(.CW(CW)) u_er_tmr (
      .clk(clk), .rst(rst), .load(er_load),
      .load_val(erase_kind[1] ? CW'(CHIP_CYC) : CW'(ERASE_CYC)),
      .run(st_q == ST_ERASE), .done(er_done));

   fws_timer #(.CW(CW)) u_sus_tmr (
      .clk(clk), .rst(rst), .load(sus_load), .load_val(CW'(SUSP_CYC)),
      .run(st_q == ST_SWAIT), .done(sus_done));

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (start_prog)       st_d = ST_PROG;
                   else if (start_erase) st_d = ST_ERASE;
         ST_PROG:  if (prog_done)        st_d = ST_IDLE;
         ST_ERASE: if (er_done)          st_d = ST_IDLE;
                   else if (suspend_req && !er_kind_q[1]) st_d = ST_SWAIT;
         ST_SWAIT: if (sus_done)         st_d = ST_SUSP;
         ST_SUSP:  if (resume_req)       st_d = ST_ERASE;
                   else if (start_prog && !hit_op) st_d = ST_SPROG;
         ST_SPROG: if (prog_done)        st_d = ST_SUSP;
         default:                        st_d = ST_IDLE;
      endcase
   end

   assign prog_load = (st_q == ST_IDLE && st_d == ST_PROG) ||
                      (st_q == ST_SUSP && st_d == ST_SPROG);
   assign er_load   = (st_q == ST_IDLE && st_d == ST_ERASE);
   assign sus_load  = (st_q == ST_ERASE && st_d == ST_SWAIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= ST_IDLE;
         er_base_q <= '0;
         er_kind_q <= 2'b00;
         poll_q    <= 1'b0;
      end else begin
         st_q <= st_d;
         if (prog_load) poll_q <= wr_poll_bit;
         if (er_load) begin
            er_base_q <= op_addr;
            er_kind_q <= erase_kind;
         end
      end
   end

   always_comb begin
      rd_data = arr_rdata;
      case (st_q)
         ST_PROG, ST_SPROG: begin
            rd_data[POLL_BIT] = ~poll_q;
            rd_data[TOG_BIT]  = tog;
         end
         ST_ERASE, ST_SWAIT: begin
            rd_data[POLL_BIT] = 1'b0;
            rd_data[TOG_BIT]  = tog;
            rd_data[RGN_BIT]  = tog;
         end
         ST_SUSP: if (hit_rd) begin
            rd_data[POLL_BIT] = 1'b1;
            rd_data[TOG_BIT]  = 1'b1;
            rd_data[RGN_BIT]  = tog;
         end
         default: ;
      endcase
   end

   assign busy    = (st_q == ST_PROG) || (st_q == ST_ERASE) ||
                    (st_q == ST_SWAIT) || (st_q == ST_SPROG);
   assign in_susp = (st_q == ST_SUSP) || (st_q == ST_SPROG);
endmodule

// File: rtl/fws_chk.sv
module fws_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          busy,
   input logic          in_susp,
   input logic          resume_req,
   input logic [DW-1:0] rd_data,
   input logic [DW-1:0] arr_rdata
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!busy && !in_susp));

   // R5
   passthru_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data[5:3] == arr_rdata[5:3]);

   // R6
   susp_entry_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(in_susp) |-> $past(busy));

   // R8
   outside_rgn_chk: assert property (@(posedge clk) disable iff (rst)
      (in_susp && !busy && rd_data[7:6] != 2'b11) |-> rd_data == arr_rdata);

   // R10
   resume_busy_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(in_susp) |-> busy);

   // R11
   idle_resume_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !in_susp && resume_req) |=> (!busy && !in_susp));
endmodule

bind flash_wstat_unit fws_chk #(.DW(DW)) u_fws_chk (
   .clk(clk), .rst(rst), .busy(busy), .in_susp(in_susp),
   .resume_req(resume_req), .rd_data(rd_data), .arr_rdata(arr_rdata));

// File: tb/tb_flash_wstat_unit.sv
module tb_flash_wstat_unit;
   localparam int AW = 12, DW = 16, SECT_W = 5, BLK_W = 8;
   localparam int PROG_CYC = 8, ERASE_CYC = 20, CHIP_CYC = 40, SUSP_CYC = 6;

   // {expected inside region, address} for a sector suspended at 12'h2A5
   localparam logic [12:0] SUS_VEC [8] = '{
      13'h12A0, 13'h12BF, 13'h12B3, 13'h029F,
      13'h02C0, 13'h0000, 13'h0FFF, 13'h12A5 };

   logic clk = 1'b0, rst = 1'b1;
   logic start_prog = 0, start_erase = 0, wr_poll_bit = 0;
   logic suspend_req = 0, resume_req = 0, rd_sel = 0;
   logic [1:0] erase_kind = 0;
   logic [AW-1:0] op_addr = 0, rd_addr = 0;
   logic [DW-1:0] arr_rdata, rd_data;
   logic busy, in_susp;
   int checks = 0, fails = 0;
   logic tog_m = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return {4'h0, a} ^ 16'hC35A ^ {a[7:0], 8'h00};
   endfunction

   assign arr_rdata = memf(rd_addr);

   flash_wstat_unit #(.AW(AW), .DW(DW), .SECT_W(SECT_W), .BLK_W(BLK_W),
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC),
      .SUSP_CYC(SUSP_CYC)) dut (
      .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
      .erase_kind(erase_kind), .op_addr(op_addr), .wr_poll_bit(wr_poll_bit),
      .suspend_req(suspend_req), .resume_req(resume_req), .rd_sel(rd_sel),
      .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
      .busy(busy), .in_susp(in_susp));

   // mode: 0 array, 1 program, 2 erase, 3 suspended region
   function automatic logic [DW-1:0] exp_rd(input int m, input logic [AW-1:0] a,
                                            input logic pb);
      logic [DW-1:0] d;
      d = memf(a);
      case (m)
         1: begin d[7] = ~pb;  d[6] = tog_m; end
         2: begin d[7] = 1'b0; d[6] = tog_m; d[2] = tog_m; end
         3: begin d[7] = 1'b1; d[6] = 1'b1;  d[2] = tog_m; end
         default: ;
      endcase
      return d;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input int m,
                         input logic pb);
      logic [DW-1:0] e;
      @(negedge clk);
      rd_addr = a; rd_sel = 1'b1;
      #1;
      e = exp_rd(m, a, pb);
      chk(req, 32'(rd_data), 32'(e));
      @(negedge clk);
      rd_sel = 1'b0;
      tog_m = ~tog_m;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0; tog_m = 1'b0;
   endtask

   task automatic do_prog(input logic [AW-1:0] a, input logic pb);
      @(negedge clk); op_addr = a; wr_poll_bit = pb; start_prog = 1'b1;
      @(negedge clk); start_prog = 1'b0;
   endtask

   task automatic do_erase(input logic [AW-1:0] a, input logic [1:0] k);
      @(negedge clk); op_addr = a; erase_kind = k; start_erase = 1'b1;
      @(negedge clk); start_erase = 1'b0;
   endtask

   task automatic do_susp();
      @(negedge clk); suspend_req = 1'b1;
      @(negedge clk); suspend_req = 1'b0;
   endtask

   task automatic do_resume();
      @(negedge clk); resume_req = 1'b1;
      @(negedge clk); resume_req = 1'b0;
   endtask

   task automatic cnt_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin @(negedge clk); n++; end
   endtask

   task automatic cnt_susp(output int n);
      n = 0;
      while (!in_susp && n < 1000) begin @(negedge clk); n++; end
   endtask

   initial begin
      #(200000 * 20);
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n;
      logic saw;
      do_reset();
      // R1 reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 in_susp", 32'(in_susp), 0);
      rd_chk("R1 read", 12'h0AB, 0, 0);

      // R2 program status, R4 toggle, R5 bit 2 from array during program
      do_prog(12'h123, 1'b1);
      rd_chk("R2 prog read", 12'h123, 1, 1'b1);
      rd_chk("R4 second read flips", 12'h124, 1, 1'b1);
      rd_chk("R5 prog bit2 array", 12'h127, 1, 1'b1);
      cnt_idle(n);
      rd_chk("R2 after program", 12'h123, 0, 0);
      do_prog(12'h040, 1'b0);
      cnt_idle(n);
      chk("R2 program duration", 32'(n), PROG_CYC);

      // R3 erase status, R5 bit 2 toggles, R4 idle clocks do not flip
      do_erase(12'h700, 2'd0);
      rd_chk("R3 erase read", 12'h700, 2, 0);
      repeat (3) @(negedge clk);
      rd_chk("R4 no flip without read", 12'h705, 2, 0);
      rd_chk("R5 erase bit2", 12'h9C3, 2, 0);
      cnt_idle(n);
      rd_chk("R3 after erase", 12'h700, 0, 0);

      // R3 chip erase duration; R11 suspend ignored during chip erase
      do_erase(12'h000, 2'd2);
      do_susp();
      n = 2; saw = 1'b0;
      while (busy && n < 1000) begin
         @(negedge clk); n++;
         if (in_susp) saw = 1'b1;
      end
      chk("R3 chip erase duration", 32'(n), CHIP_CYC);
      chk("R11 chip suspend ignored", 32'(saw), 0);

      // R11 start during program ignored; resume in idle ignored
      do_prog(12'h010, 1'b0);
      do_erase(12'h020, 2'd0);
      cnt_idle(n);
      @(negedge clk);
      chk("R11 erase during program", 32'(busy), 0);
      do_resume();
      chk("R11 idle resume", 32'({busy, in_susp}), 0);
      rd_chk("R11 idle read", 12'h020, 0, 0);

      // R6 suspend entry with erase status held, R7/R8 region table
      do_erase(12'h2A5, 2'd0);
      rd_chk("R3 sector erase read", 12'h2A5, 2, 0);
      do_susp();
      rd_chk("R6 erase status during entry", 12'h2A5, 2, 0);
      chk("R6 busy during entry", 32'({busy, in_susp}), 32'h2);
      cnt_susp(n);
      chk("R6 suspended flags", 32'({busy, in_susp}), 32'h1);
      for (int i = 0; i < 8; i++) begin
         if (SUS_VEC[i][12]) rd_chk("R7 inside sector", SUS_VEC[i][11:0], 3, 0);
         else                rd_chk("R8 outside sector", SUS_VEC[i][11:0], 0, 0);
      end

      // R9 program inside region ignored, outside runs
      do_prog(12'h2B0, 1'b1);
      chk("R9 inside program ignored", 32'({busy, in_susp}), 32'h1);
      rd_chk("R9 region after ignored", 12'h2B0, 3, 0);
      do_prog(12'h500, 1'b0);
      chk("R9 suspended program busy", 32'({busy, in_susp}), 32'h3);
      rd_chk("R9 suspended program read", 12'h500, 1, 1'b0);
      cnt_idle(n);
      chk("R9 back to suspend", 32'({busy, in_susp}), 32'h1);
      rd_chk("R9 array after program", 12'h500, 0, 0);

      // R10 resume continues erase
      do_resume();
      chk("R10 resume flags", 32'({busy, in_susp}), 32'h2);
      rd_chk("R10 erase status again", 12'h2A5, 2, 0);
      cnt_idle(n);
      rd_chk("R10 erase finished", 12'h2A5, 0, 0);

      // R6 / R10 timed: suspend after six erase cycles
      do_erase(12'h100, 2'd0);
      repeat (4) @(negedge clk);
      do_susp();
      cnt_susp(n);
      chk("R6 entry delay", 32'(n), SUSP_CYC);
      do_resume();
      cnt_idle(n);
      chk("R10 remaining erase", 32'(n), ERASE_CYC - 6);

      // R8 block region, R12 reset while suspended
      do_erase(12'h345, 2'd1);
      do_susp();
      cnt_susp(n);
      rd_chk("R7 block top word", 12'h3FF, 3, 0);
      rd_chk("R7 block bottom word", 12'h300, 3, 0);
      rd_chk("R8 above block", 12'h400, 0, 0);
      rd_chk("R8 below block", 12'h2FF, 0, 0);
      do_reset();
      chk("R12 reset in suspend", 32'({busy, in_susp}), 0);
      rd_chk("R12 read after reset", 12'h3FF, 0, 0);

      // R12 reset during erase
      do_erase(12'h800, 2'd1);
      repeat (3) @(negedge clk);
      do_reset();
      chk("R12 reset during erase", 32'({busy, in_susp}), 0);
      rd_chk("R12 array after abort", 12'h800, 0, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule